// File: doc/BRIEF.md
# Two-Mode Radix-4 Recoding Multiplier

This block multiplies two unsigned operands of `W` bits (14 by default) and returns the full `2*W`-bit product. It consumes the multiplier two bits per clock. A two-state recoder keeps track of a pending borrow. It picks one action for each bit pair from four choices: nothing, add the multiplicand, add twice the multiplicand, or subtract the multiplicand. A group of value three therefore costs a single subtraction plus a carry into the next group, so no addition of three times the multiplicand is ever needed.

The lowest multiplier bit is handled on its own in the step that accepts the operands. The remaining bits are then taken as `W/2` pairs, with any missing top bit read as zero. After each pair, the running sum moves two places to the right. If a borrow is still pending after the last pair, one final step adds the multiplicand back at the top weight. The block works on magnitudes only. A surrounding unit pulses `start` with both operands, waits for `done`, and applies any sign itself.

Top module: `pairwise_borrow_mult`

## Requirements
- R1: One cycle after `done` is high, `product` equals `mcand * mplier` for every pair of unsigned `W`-bit operands.
- R2: `start` is accepted on a rising clock edge only while `busy` is low, and `busy` is high in the cycle that follows.
- R3: `done` is high for exactly one cycle. It rises on the `W/2 + 1`-th rising edge after the accepting edge, and `busy` falls on the same edge.
- R4: A `start` pulse applied while `busy` is high is ignored. The run in progress keeps its latency and its result, and no second run follows.
- R5: `product` changes only on the edge that raises `done`, and it holds its value while new operands are presented without `start`.
- R6: While reset is asserted, and after it is released, `busy`, `done` and `product` are all zero until the first accepted `start`.
- R7: When the top pair leaves a borrow pending (odd `W` with all-ones multiplier), the final correction yields the exact product.
- R8: Multiplier patterns whose pairs run 11 then 10, 10, ..., which keep the borrow state active across many steps, produce the exact product.
- R9: A zero multiplicand or a zero multiplier gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Operation request, sampled when idle |
| mcand | input | W | Unsigned multiplicand |
| mplier | input | W | Unsigned multiplier |
| product | output | 2*W | Unsigned product, held until the next completion |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One copy uses the default even width of 14 bits. The other uses an odd width of 13 bits. With the even width, the top pair always has a zero upper bit, so any pending borrow is cleared before the end and the correction step is never exercised. The 13-bit copy has a full top pair, so an all-ones multiplier reaches the final add-back and its six-pair latency is checked as well.

// File: rtl/pbm_pkg.sv
`timescale 1ns/1ps
package pbm_pkg;

  // recoder state: whether a carry of one is owed to the current pair
  typedef enum logic {
    MODE_NORM   = 1'b0,
    MODE_BORROW = 1'b1
  } mode_e;

  // action applied to the running sum for one pair
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ADD1 = 2'd1,
    ACT_ADD2 = 2'd2,
    ACT_SUB1 = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAIR = 2'd1,
    ST_FIX  = 2'd2
  } state_e;

endpackage

// File: rtl/pbm_recoder.sv
`timescale 1ns/1ps
module pbm_recoder
  import pbm_pkg::*;
(
  input  logic [1:0] pair_i,
  input  mode_e      mode_i,
  output act_e       act_o,
  output mode_e      mode_o
);

  // effective digit = pair + pending borrow; digit 3 -> -1 with carry, 4 -> 0 with carry
  always_comb begin
    act_o  = ACT_NONE;
    mode_o = mode_i;
    unique case ({mode_i, pair_i})
      {MODE_NORM, 2'b00}:   begin act_o = ACT_NONE; mode_o = MODE_NORM;   end
      {MODE_NORM, 2'b01}:   begin act_o = ACT_ADD1; mode_o = MODE_NORM;   end
      {MODE_NORM, 2'b10}:   begin act_o = ACT_ADD2; mode_o = MODE_NORM;   end
      {MODE_NORM, 2'b11}:   begin act_o = ACT_SUB1; mode_o = MODE_BORROW; end
      {MODE_BORROW, 2'b00}: begin act_o = ACT_ADD1; mode_o = MODE_NORM;   end
      {MODE_BORROW, 2'b01}: begin act_o = ACT_ADD2; mode_o = MODE_NORM;   end
      {MODE_BORROW, 2'b10}: begin act_o = ACT_SUB1; mode_o = MODE_BORROW; end
      {MODE_BORROW, 2'b11}: begin act_o = ACT_NONE; mode_o = MODE_BORROW; end
      default:              begin act_o = ACT_NONE; mode_o = mode_i;      end
    endcase
  end

endmodule

// File: rtl/pbm_addend.sv
`timescale 1ns/1ps
module pbm_addend
  import pbm_pkg::*;
#(
  parameter int W  = 14,
  parameter int HW = W + 4
) (
  input  act_e                  act_i,
  input  logic [W-1:0]          mcand_i,
  output logic signed [HW-1:0]  addend_o
);

  logic signed [HW-1:0] m_ext;

  assign m_ext = $signed({{(HW-W){1'b0}}, mcand_i});

  always_comb begin
    unique case (act_i)
      ACT_ADD1: addend_o = m_ext;
      ACT_ADD2: addend_o = m_ext <<< 1;
      ACT_SUB1: addend_o = -m_ext;
      default:  addend_o = '0;
    endcase
  end

endmodule

// File: rtl/pbm_rst_sync.sv
`timescale 1ns/1ps
module pbm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];

endmodule

// File: rtl/pairwise_borrow_mult.sv
`timescale 1ns/1ps
module pairwise_borrow_mult
  import pbm_pkg::*;
#(
  parameter int W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  output logic [2*W-1:0]   product,
  output logic             busy,
  output logic             done
);

  localparam int NPAIR = W / 2;            // pairs after the single low bit
  localparam int PW    = 2 * NPAIR;        // multiplier bits left after bit 0
  localparam int LW    = PW + 1;           // low product bits shifted out
  localparam int HW    = W + 4;            // signed running-sum width
  localparam int CW    = $clog2(NPAIR + 1);
  localparam int FW    = HW + LW;

  logic rst_n_sync;

  state_e               st_q,    st_d;
  logic [CW-1:0]        cnt_q,   cnt_d;
  mode_e                mode_q,  mode_d;
  logic [W-1:0]         m_q,     m_d;
  logic [PW-1:0]        b_q,     b_d;
  logic signed [HW-1:0] h_q,     h_d;
  logic [LW-1:0]        l_q,     l_d;
  logic [2*W-1:0]       prod_q,  prod_d;
  logic                 done_q,  done_d;

  logic                 load_en, pair_en, fix_en, step_en;
  act_e                 act;
  mode_e                mode_nx;
  logic signed [HW-1:0] addend;
  logic signed [HW-1:0] sum;
  logic signed [HW-1:0] corr;
  logic signed [HW-1:0] h_fix;
  logic [FW-1:0]        full;

  pbm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  pbm_recoder u_rec (
    .pair_i (b_q[1:0]),
    .mode_i (mode_q),
    .act_o  (act),
    .mode_o (mode_nx)
  );

  pbm_addend #(.W(W), .HW(HW)) u_add (
    .act_i    (act),
    .mcand_i  (m_q),
    .addend_o (addend)
  );

  // clock enables
  assign load_en = (st_q == ST_IDLE) && start;
  assign pair_en = (st_q == ST_PAIR);
  assign fix_en  = (st_q == ST_FIX);
  assign step_en = load_en || pair_en;

  // datapath arithmetic
  assign sum   = h_q + addend;
  assign corr  = (mode_q == MODE_BORROW) ? $signed({{(HW-W){1'b0}}, m_q}) : '0;
  assign h_fix = h_q + corr;
  assign full  = {h_fix, l_q};

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    m_d    = m_q;
    b_d    = b_q;
    h_d    = h_q;
    l_d    = l_q;
    prod_d = prod_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          // bit 0 alone: sum is mcand or zero at weight 1, kept as half plus one shifted bit
          m_d    = mcand;
          b_d    = PW'(mplier >> 1);
          h_d    = mplier[0] ? $signed({{(HW-W+1){1'b0}}, mcand[W-1:1]}) : '0;
          l_d    = {mplier[0] & mcand[0], l_q[LW-1:1]};
          mode_d = MODE_NORM;
          cnt_d  = '0;
          st_d   = ST_PAIR;
        end
      end
      ST_PAIR: begin
        h_d    = sum >>> 2;
        l_d    = {sum[1:0], l_q[LW-1:2]};
        b_d    = b_q >> 2;
        mode_d = mode_nx;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(NPAIR - 1)) st_d = ST_FIX;
      end
      ST_FIX: begin
        prod_d = full[2*W-1:0];
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= MODE_NORM;
      m_q    <= '0;
      b_q    <= '0;
      h_q    <= '0;
      l_q    <= '0;
      prod_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (load_en) begin
        m_q <= m_d;
      end
      if (step_en) begin
        cnt_q  <= cnt_d;
        mode_q <= mode_d;
        b_q    <= b_d;
        h_q    <= h_d;
        l_q    <= l_d;
      end
      if (fix_en) begin
        prod_q <= prod_d;
      end
    end
  end

  assign product = prod_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;

endmodule

// File: rtl/pbm_checker.sv
`timescale 1ns/1ps
module pbm_checker #(
  parameter int W = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic [2*W-1:0] product,
  input logic           busy,
  input logic           done
);

  localparam int NP = W / 2;
  localparam int BW = $clog2(NP + 3) + 1;

  logic [2*W-1:0] exp_q;
  logic [BW-1:0]  bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= '0;
      bcnt_q <= '0;
    end else begin
      if (start && !busy) exp_q <= (2*W)'(mcand) * (2*W)'(mplier);
      if (busy) bcnt_q <= bcnt_q + 1'b1;
      else      bcnt_q <= '0;
    end
  end

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == exp_q)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bcnt_q == BW'(NP + 1))); // R3

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done); // R5

endmodule

bind pairwise_borrow_mult pbm_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .product (product),
  .busy    (busy),
  .done    (done)
);

// File: tb/pairwise_borrow_mult_test.sv
`timescale 1ns/1ps
module pairwise_borrow_mult_test;

  localparam int WE = 14;   // even width
  localparam int WO = 13;   // odd width: top pair is full
  localparam int NV = 12;

  localparam logic [13:0] TBL_A [NV] = '{
    14'h0001, 14'h3FFF, 14'h3FFF, 14'h0001, 14'h2345, 14'h1ABC,
    14'h3FFF, 14'h2AAA, 14'h1555, 14'h0F0F, 14'h3FFE, 14'h0002
  };
  localparam logic [13:0] TBL_B [NV] = '{
    14'h0001, 14'h0001, 14'h3FFF, 14'h3FFF, 14'h2AAF, 14'h1557,
    14'h3557, 14'h1556, 14'h2AAA, 14'h3FFD, 14'h3FFE, 14'h1FFF
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic                 start;
  logic [WE-1:0]        ma, mb;
  logic [2*WE-1:0]      prod_e;
  logic [2*WO-1:0]      prod_o;
  logic                 busy_e, done_e, busy_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  pairwise_borrow_mult #(.W(WE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(ma), .mplier(mb),
    .product(prod_e), .busy(busy_e), .done(done_e)
  );

  pairwise_borrow_mult #(.W(WO)) uut_odd (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(ma[WO-1:0]), .mplier(mb[WO-1:0]),
    .product(prod_o), .busy(busy_o), .done(done_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_mul(input logic [13:0] a, input logic [13:0] b, input bit inject,
                        input string tag);
    int lat_e;
    int lat_o;
    logic [2*WE-1:0] exp_e;
    logic [2*WO-1:0] exp_o;
    exp_e = (2*WE)'(a) * (2*WE)'(b);
    exp_o = (2*WO)'(a[WO-1:0]) * (2*WO)'(b[WO-1:0]);
    @(negedge clk);
    start = 1'b1; ma = a; mb = b;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after accept (even)"}, 64'(busy_e), 64'd1);
    chk({tag, " R2 busy after accept (odd)"},  64'(busy_o), 64'd1);
    lat_e = -1;
    lat_o = -1;
    for (int k = 1; k <= 40; k++) begin
      if (inject && k == 3) begin start = 1'b1; ma = ~a; mb = ~b; end
      @(negedge clk);
      if (inject && k == 3) begin start = 1'b0; ma = a; mb = b; end
      if (done_e && lat_e < 0) lat_e = k;
      if (done_o && lat_o < 0) lat_o = k;
      if (lat_e >= 0 && lat_o >= 0) break;
    end
    chk({tag, " R3 latency (even)"}, 64'(lat_e), 64'(WE / 2 + 1));
    chk({tag, " R3 latency (odd)"},  64'(lat_o), 64'(WO / 2 + 1));
    chk({tag, " R1 product (even)"}, 64'(prod_e), 64'(exp_e));
    chk({tag, " R1 product (odd)"},  64'(prod_o), 64'(exp_o));
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, 64'({done_e, done_o}), 64'd0);
    if (inject) begin
      chk({tag, " R4 no second run (even)"}, 64'(busy_e), 64'd0);
      chk({tag, " R4 no second run (odd)"},  64'(busy_o), 64'd0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    ma    = '0;
    mb    = '0;
    repeat (3) @(negedge clk);
    chk("R6 reset state in reset", 64'({busy_e, done_e, busy_o, done_o}), 64'd0);
    chk("R6 product zero in reset", 64'(prod_e) | 64'(prod_o), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 idle after release", 64'({busy_e, done_e, busy_o, done_o}), 64'd0);
    chk("R6 product zero after release", 64'(prod_e) | 64'(prod_o), 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) do_mul(TBL_A[i], TBL_B[i], 1'b0, "table");

    // zero operands
    do_mul(14'h0000, 14'h3FFF, 1'b0, "R9 zero mcand");
    do_mul(14'h3FFF, 14'h0000, 1'b0, "R9 zero mplier");
    do_mul(14'h0000, 14'h0000, 1'b0, "R9 both zero");

    // pending borrow at end (odd width all-ones multiplier)
    do_mul(14'h1FFF, 14'h1FFF, 1'b0, "R7 final correction");
    do_mul(14'h0001, 14'h1FFF, 1'b0, "R7 correction unit mcand");

    // borrow kept active by 11,10,10,... pairs
    do_mul(14'h3FFF, 14'h1557, 1'b0, "R8 borrow chain");
    do_mul(14'h2ACE, 14'h0D57, 1'b0, "R8 borrow chain odd");

    // start while busy
    do_mul(14'h1234, 14'h0FED, 1'b1, "R4 ignored start");

    // product held while inputs change without start
    do_mul(14'h0ABC, 14'h3210, 1'b0, "R5 setup");
    begin
      logic [2*WE-1:0] held_e;
      logic [2*WO-1:0] held_o;
      held_e = prod_e;
      held_o = prod_o;
      ma = 14'h3FFF; mb = 14'h3FFF;
      repeat (6) @(negedge clk);
      chk("R5 product held (even)", 64'(prod_e), 64'(held_e));
      chk("R5 product held (odd)",  64'(prod_o), 64'(held_o));
    end

    // random operands
    for (int r = 0; r < 60; r++) do_mul(14'($urandom), 14'($urandom), 1'b0, "R1 random");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule